// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Bus-Quiet Decision Strobe

This block runs one successive-approximation conversion per start pulse. It divides its clock by four into bit-trial periods. It drives a 12-bit trial code to an external DAC and comparator, and takes a single comparator bit back. It settles the twelve data bits from the most significant to the least significant. A thirteenth trial then decides whether the input lies above full scale. After a last four-clock transfer period, it presents the 13-bit word to a FIFO with a one-cycle write enable.

Bus traffic on the same die can disturb a comparator decision. For that reason, the block samples a bus-activity condition on the falling clock edge before every candidate decision edge. The condition is chip select low together with read or write low. If it is true, the decision slips to the next rising edge. The check is made again before each new candidate edge, so a decision can slip any number of times.

The control is a three-state machine:
- ST_IDLE moves to ST_TRIAL on a start pulse.
- ST_TRIAL stays in ST_TRIAL on each decision or slip, and moves to ST_XFER on the thirteenth decision.
- ST_XFER moves to ST_IDLE once its four-clock period ends.

Top module: `sarseq_top`

## Requirements
- R1: After reset, busy_o and fifo_we_o are low.
- R2: A start_i high sampled in idle raises busy_o on the following cycle and loads dac_code_o with 0x800 (only bit 11 set).
- R3: With no bus activity, the first decision is latched on the fourth rising edge after the start edge. Later decisions follow every four clocks from bit 11 down to bit 0. A comparator value of 1 keeps the bit under trial, and the next lower bit is then set for its trial.
- R4: The thirteenth decision is the range check. During it, oor_trial_o is high and dac_code_o holds the finished 12-bit result. A comparator value of 1 sets the range flag.
- R5: If, at the falling edge before a candidate decision edge, cs_n_i is low and rd_n_i or wr_n_i is low, that decision is deferred by exactly one clock. The test repeats before each new candidate edge.
- R6: Bus activity sampled at any falling edge that does not precede a candidate decision edge has no effect on timing or result.
- R7: busy_o stays high for exactly 56 cycles plus the number of deferrals.
- R8: fifo_we_o is high for exactly one cycle per conversion, on the last busy cycle. fifo_data_o carries the range flag in bit 12 and the result in bits 11:0.
- R9: A start_i pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on rising edge |
| cmp_i | input | 1 | Comparator result, 1 = input at or above trial level |
| cs_n_i | input | 1 | Bus chip select, active low |
| rd_n_i | input | 1 | Bus read strobe, active low |
| wr_n_i | input | 1 | Bus write strobe, active low |
| dac_code_o | output | 12 | Trial code to the DAC |
| oor_trial_o | output | 1 | High during the range-check trial |
| busy_o | output | 1 | Conversion in progress |
| fifo_we_o | output | 1 | One-cycle FIFO write enable |
| fifo_data_o | output | 13 | {range flag, 12-bit result} |

## Verification
The assertions assume three things about the inputs:
- the bus strobes are stable around the falling clock edge;
- the comparator answer settles before the rising edge that latches it;
- reset is held long enough to clear both the rising-edge registers and the falling-edge registers.

The bench meets these by changing every input one nanosecond after a rising edge, and by deriving the comparator from the trial code combinationally. The bus patterns are random per cycle, directed bursts over several candidate edges, and activity placed only outside the sensitive windows. Start pulses are also injected mid-conversion.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_XFER  = 2'd2
    } sarseq_state_e;
endpackage

// File: rtl/sarseq_bus_guard.sv
module sarseq_bus_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic hit_o
);
    // Captured in the low half of the clock, ahead of the next rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hit_o <= 1'b0;
        else        hit_o <= !cs_n_i && (!rd_n_i || !wr_n_i);
    end
endmodule

// File: rtl/sarseq_phase_timer.sv
module sarseq_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic hold_i,
    output logic last_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign last_o = (phase == LAST_PH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        phase <= '0;
        else if (clear_i)  phase <= '0;
        else if (!hold_i)  phase <= last_o ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/sarseq_sar_reg.sv
module sarseq_sar_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         decide_i,
    input  logic         cmp_i,
    output logic [W-1:0] code_o,
    output logic         range_o,
    output logic         range_phase_o
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code;
    logic [W-1:0] mask;
    logic         range_flag;

    assign code_o        = code;
    assign range_o       = range_flag;
    assign range_phase_o = (mask == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code       <= '0;
            mask       <= '0;
            range_flag <= 1'b0;
        end else if (load_i) begin
            code       <= TOP_BIT;
            mask       <= TOP_BIT;
            range_flag <= 1'b0;
        end else if (decide_i) begin
            if (mask != '0) begin
                code <= (cmp_i ? code : (code & ~mask)) | (mask >> 1);
                mask <= mask >> 1;
            end else begin
                range_flag <= cmp_i;
            end
        end
    end
endmodule

// File: rtl/sarseq_top.sv
module sarseq_top #(
    parameter int W   = 12,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    input  logic         cs_n_i,
    input  logic         rd_n_i,
    input  logic         wr_n_i,
    output logic [W-1:0] dac_code_o,
    output logic         oor_trial_o,
    output logic         busy_o,
    output logic         fifo_we_o,
    output logic [W:0]   fifo_data_o
);
    import sarseq_pkg::*;

    sarseq_state_e state, state_nx;
    logic bus_hit, tmr_last, range_phase, range_flag;
    logic decide, load, slip;

    assign slip   = (state == ST_TRIAL) && tmr_last && bus_hit;
    assign decide = (state == ST_TRIAL) && tmr_last && !bus_hit;
    assign load   = (state == ST_IDLE) && start_i;

    sarseq_bus_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_i (cs_n_i),
        .rd_n_i (rd_n_i),
        .wr_n_i (wr_n_i),
        .hit_o  (bus_hit)
    );

    sarseq_phase_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state == ST_IDLE),
        .hold_i  (slip),
        .last_o  (tmr_last)
    );

    sarseq_sar_reg #(.W(W)) u_sar (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .decide_i      (decide),
        .cmp_i         (cmp_i),
        .code_o        (dac_code_o),
        .range_o       (range_flag),
        .range_phase_o (range_phase)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_i)                state_nx = ST_TRIAL;
            ST_TRIAL: if (decide && range_phase)  state_nx = ST_XFER;
            ST_XFER:  if (tmr_last)               state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        busy_o      = (state != ST_IDLE);
        fifo_we_o   = (state == ST_XFER) && tmr_last;
        oor_trial_o = (state == ST_TRIAL) && range_phase;
        fifo_data_o = {range_flag, dac_code_o};
    end
endmodule

// File: rtl/sarseq_chk.sv
module sarseq_chk #(
    parameter int W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    fifo_we_o,
    input logic                    oor_trial_o,
    input logic [W-1:0]            dac_code_o,
    input logic [W:0]              fifo_data_o,
    input sarseq_pkg::sarseq_state_e state_i,
    input logic                    last_i,
    input logic                    hit_i
);
    import sarseq_pkg::*;

    // R2: start in idle loads the top trial bit
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && dac_code_o == {1'b1, {(W-1){1'b0}}}));

    // R5: a deferred strobe leaves the trial state untouched
    a_r5_slip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_TRIAL && last_i && hit_i) |=>
        ($stable(dac_code_o) && $stable(oor_trial_o) && $stable(fifo_data_o[W])));

    // R8: write enable only while busy and only for one cycle
    a_r8_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we_o |-> busy_o);
    a_r8_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we_o |=> !fifo_we_o);

    // R7: busy ends right after the write, and only there
    a_r7_idle_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we_o |=> !busy_o);
    a_r7_fall_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(fifo_we_o));

    // R9: a start during a non-deciding trial cycle changes nothing
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_TRIAL && start_i && !last_i) |=> (busy_o && $stable(dac_code_o)));
endmodule

bind sarseq_top sarseq_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .fifo_we_o   (fifo_we_o),
    .oor_trial_o (oor_trial_o),
    .dac_code_o  (dac_code_o),
    .fifo_data_o (fifo_data_o),
    .state_i     (state),
    .last_i      (tmr_last),
    .hit_i       (bus_hit)
);

// File: tb/sarseq_top_tb_top.sv
module sarseq_top_tb_top;
    localparam int W = 12;
    localparam int FULL = (1 << W) - 1;
    localparam int BASE_LEN = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cs_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1;
    logic cmp_i;
    logic [W-1:0] dac_code_o;
    logic oor_trial_o, busy_o, fifo_we_o;
    logic [W:0] fifo_data_o;
    int vin_r = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign cmp_i = oor_trial_o ? (vin_r >= int'(dac_code_o) + 1) : (vin_r >= int'(dac_code_o));

    sarseq_top #(.W(W), .DIV(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
        .dac_code_o(dac_code_o), .oor_trial_o(oor_trial_o), .busy_o(busy_o),
        .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_result(input int v);
        return (v > FULL) ? FULL : v;
    endfunction

    function automatic bit exp_range(input int v);
        return v > FULL;
    endfunction

    // mode 0 quiet, 1 random strobes, 2 burst over three candidates, 3 off-window only
    task automatic run_conv(input int vin, input int mode, input int extra_start);
        int c, nt, slips, len, wecnt, first_e, pend, e;
        bit act, cs, rd, wr;
        logic [W:0] wdata;
        int res;
        res = exp_result(vin);
        vin_r = vin;
        wdata = '0;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk);
        c = 0; nt = 0; slips = 0; len = 0; wecnt = 0; first_e = -1; pend = 0; e = 0;
        for (int k = 0; k < 400; k++) begin
            #1;
            start_i = (k == extra_start);
            unique case (mode)
                1: begin cs = 1'($urandom % 2); rd = 1'($urandom % 2); wr = 1'($urandom % 2); end
                2: begin cs = !(nt == 5 && slips < 3); rd = cs; wr = 1'b1; end
                3: begin cs = (c == 3 && nt < W + 1); rd = 1'b0; wr = 1'($urandom % 2); end
                default: begin cs = 1'b1; rd = 1'b1; wr = 1'b1; end
            endcase
            cs_n_i = cs; rd_n_i = rd; wr_n_i = wr;
            act = !cs && (!rd || !wr);
            #1;
            if (!busy_o) break;
            len++;
            if (fifo_we_o) begin wecnt++; wdata = fifo_data_o; end
            if (k == 0) check(dac_code_o == 12'h800, "R2", "initial trial code", int'(dac_code_o), 'h800);
            if (pend >= 1 && pend <= W)
                check(dac_code_o[W-pend] == res[W-pend], "R3", "decided bit", int'(dac_code_o[W-pend]), res[W-pend]);
            if (pend == W) begin
                check(oor_trial_o == 1'b1, "R4", "range trial flag", int'(oor_trial_o), 1);
                check(int'(dac_code_o) == res, "R4", "code during range trial", int'(dac_code_o), res);
            end
            pend = 0;
            @(posedge clk); e++;
            if (nt < W + 1) begin
                if (c == 3) begin
                    if (act) slips++;
                    else begin nt++; c = 0; pend = nt; if (nt == 1) first_e = e; end
                end else c++;
            end
        end
        start_i = 1'b0; cs_n_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1;
        check(len == BASE_LEN + slips, "R7", "busy length", len, BASE_LEN + slips);
        check(wecnt == 1, "R8", "write pulses", wecnt, 1);
        check(int'(wdata[W-1:0]) == res, "R8", "fifo result", int'(wdata[W-1:0]), res);
        check(wdata[W] == exp_range(vin), "R4", "range flag", int'(wdata[W]), int'(exp_range(vin)));
        if (mode == 0) check(first_e == 4, "R3", "first decision edge", first_e, 4);
        if (mode == 2) check(slips == 3, "R5", "repeated deferrals", slips, 3);
        if (mode == 3) check(len == BASE_LEN, "R6", "off-window activity length", len, BASE_LEN);
        if (extra_start >= 0) check(len == BASE_LEN + slips, "R9", "start while busy", len, BASE_LEN + slips);
        @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd2468));
        repeat (3) @(posedge clk);
        #2;
        check(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
        check(fifo_we_o == 1'b0, "R1", "we after reset", int'(fifo_we_o), 0);
        #1 rst_n = 1'b1;
        run_conv(0, 0, -1);
        run_conv(FULL, 0, -1);
        run_conv(2730, 0, -1);
        run_conv(5000, 0, -1);
        run_conv(1234, 2, -1);
        run_conv(3000, 3, -1);
        run_conv(777, 1, 10);
        run_conv(4096, 1, 54);
        for (int i = 0; i < 20; i++) run_conv(int'($urandom % 5000), 1, -1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule